// File: doc/BRIEF.md
# Light-Load Pulse-Skipping Mode Controller

This block sits beside the fixed-frequency modulator of a synchronous buck converter and decides, cycle by cycle, whether the power stage follows the PWM modulator or runs a light-load scheme. In that scheme the block issues a high-side pulse of constant width, keeps the low side on until the inductor current reaches zero, and then holds both switches off until the output sags. The analog side delivers one-clock strobes for switching-cycle boundaries and current zero crossings. It also delivers level flags for "current still positive", "sense below reference", "sense below 95 % of reference", tracking mode, "reference ramp finished and calibration sampled", and a mode-enable bit.

Light-load operation begins only after a run of switching cycles that each contain a zero crossing. It ends at once on a deep output droop, or after a run of zero crossings at which the output was still below the reference. Tracking mode, a pending reference change and a cleared enable bit all lock the mode out. In PWM mode the switch outputs copy the modulator's commands unchanged.

Top module: `lla_mode_ctrl`

## Requirements
- R1: With the lockout inactive, `ll_mode` goes high on the clock edge at which `cyc_start` closes the 8th (ENTRY_CNT) consecutive switching cycle that contained a `zc_evt`. A `zc_evt` in the same clock as `cyc_start` counts toward the cycle being closed.
- R2: In light-load mode each high-side pulse lasts exactly TON_CYC (4) clocks, with `hs_on`=1 and `ls_on`=0.
- R3: After the pulse, `ls_on` stays 1 until the clock edge at which `zc_evt` is sampled, and then both outputs are 0. In light-load mode `hs_on` and `ls_on` are never 1 together.
- R4: While both switches are off in light-load mode, the next pulse starts on the edge at which `vs_below_ref`=1 and `i_pos`=0. Until then both outputs stay 0.
- R5: If `vs_below_ref`=1 while `i_pos`=1, the pulse is held back and `hs_on` stays 0 until `i_pos` returns to 0.
- R6: `vs_below_95`=1 in light-load mode returns the block to PWM on the next edge, whatever phase the pulse sequence is in.
- R7: A zero crossing during the low-side phase counts when `vs_below_ref`=1 and resets the count when it is 0. The 3rd (EXIT_CNT) consecutive counted crossing returns the block to PWM on that edge.
- R8: With `track_mode`=1, light-load mode is never entered, and it is left on the next edge if active.
- R9: With `ref_settled`=0, light-load mode is unavailable and is left on the next edge. After `ref_settled` returns, a full new run of ENTRY_CNT cycles is needed to re-enter.
- R10: With `ll_enable`=0, the block stays in PWM and the entry run count is cleared.
- R11: A switching cycle closed by `cyc_start` without any `zc_evt` resets the entry run count to zero.
- R12: After reset `ll_mode`=0. While `ll_mode`=0, `hs_on` and `ls_on` equal `pwm_hs` and `pwm_ls`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_enable | input | 1 | Permits light-load operation |
| track_mode | input | 1 | Tracking operation active; forces continuous conduction |
| ref_settled | input | 1 | Reference ramp finished and calibration sample taken |
| cyc_start | input | 1 | One-clock strobe closing a PWM switching cycle |
| zc_evt | input | 1 | One-clock strobe: inductor current crossed zero |
| i_pos | input | 1 | Inductor current still positive |
| vs_below_ref | input | 1 | Sensed output below the reference |
| vs_below_95 | input | 1 | Sensed output below 95 % of the reference |
| pwm_hs | input | 1 | High-side command from the PWM modulator |
| pwm_ls | input | 1 | Low-side command from the PWM modulator |
| ll_mode | output | 1 | Light-load mode active |
| hs_on | output | 1 | High-side switch command |
| ls_on | output | 1 | Low-side switch command |

## Verification
The properties assume that `cyc_start` and `zc_evt` are single-clock strobes, that `zc_evt` arrives only while current is flowing, and that `pwm_hs` and `pwm_ls` are never high together. The stimulus drives each strobe for exactly one clock and keeps the modulator commands complementary. In the light-load phases it changes the comparator levels only between strobes, so every counted event sees one well-defined comparator value. Entry-run breaks are swept over every position before the threshold, and exit runs are interrupted once before completing.

// File: rtl/lla_pkg.sv
package lla_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_HIGH = 2'd1,
      SEQ_LOW  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/lla_run_counter.sv
// Counts consecutive qualifying events; any non-qualifying strobe restarts the run.
module lla_run_counter #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   input  logic hit,
   output logic done
);
   generate
      if (LIMIT == 1) begin : g_single
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign done = !clr && step && hit;
      end else begin : g_count
         localparam int CW = $clog2(LIMIT);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt_q;

         assign done = !clr && step && hit && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr) begin
               cnt_q <= '0;
            end else if (step) begin
               if (!hit || cnt_q == LAST) cnt_q <= '0;
               else                       cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lla_pulse_seq.sv
// Pulse / diode-emulation / idle sequencer for light-load operation.
module lla_pulse_seq
   import lla_pkg::*;
#(
   parameter int TON_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       fire_req,
   input  logic       i_pos,
   input  logic       zc_evt,
   output seq_state_e state,
   output logic       zc_in_low
);
   localparam int TW = (TON_CYC > 1) ? $clog2(TON_CYC) : 1;
   localparam logic [TW-1:0] TLOAD = TW'(TON_CYC - 1);

   seq_state_e st_q;
   logic [TW-1:0] ton_q;

   assign state     = st_q;
   assign zc_in_low = (st_q == SEQ_LOW) && zc_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         ton_q <= '0;
      end else if (!run) begin
         st_q  <= SEQ_IDLE;
         ton_q <= '0;
      end else begin
         unique case (st_q)
            SEQ_IDLE: if (fire_req && !i_pos) begin
               st_q  <= SEQ_HIGH;
               ton_q <= TLOAD;
            end
            SEQ_HIGH: if (ton_q == '0) st_q <= SEQ_LOW;
                      else             ton_q <= ton_q - 1'b1;
            SEQ_LOW:  if (zc_evt) st_q <= SEQ_IDLE;
            default:  st_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lla_drive_mux.sv
// Selects modulator commands or sequencer-derived commands.
module lla_drive_mux
   import lla_pkg::*;
(
   input  logic       ll_mode,
   input  seq_state_e state,
   input  logic       pwm_hs,
   input  logic       pwm_ls,
   output logic       hs_on,
   output logic       ls_on
);
   always_comb begin
      if (ll_mode) begin
         hs_on = (state == SEQ_HIGH);
         ls_on = (state == SEQ_LOW);
      end else begin
         hs_on = pwm_hs;
         ls_on = pwm_ls;
      end
   end
endmodule

// File: rtl/lla_mode_ctrl.sv
module lla_mode_ctrl
   import lla_pkg::*;
#(
   parameter int ENTRY_CNT = 8,
   parameter int EXIT_CNT  = 3,
   parameter int TON_CYC   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ll_enable,
   input  logic track_mode,
   input  logic ref_settled,
   input  logic cyc_start,
   input  logic zc_evt,
   input  logic i_pos,
   input  logic vs_below_ref,
   input  logic vs_below_95,
   input  logic pwm_hs,
   input  logic pwm_ls,
   output logic ll_mode,
   output logic hs_on,
   output logic ls_on
);
   generate
      if (ENTRY_CNT < 1) begin : g_bad_entry
         $error("ENTRY_CNT must be at least 1");
      end
      if (EXIT_CNT < 1) begin : g_bad_exit
         $error("EXIT_CNT must be at least 1");
      end
      if (TON_CYC < 1) begin : g_bad_ton
         $error("TON_CYC must be at least 1");
      end
   endgenerate

   logic       allowed;
   logic       zc_seen_q;
   logic       mode_q;
   logic       entry_done;
   logic       exit_done;
   logic       leave;
   logic       run;
   logic       zc_in_low;
   seq_state_e state;

   assign allowed = ll_enable && !track_mode && ref_settled;

   // a zero crossing anywhere in the open switching cycle marks it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         zc_seen_q <= 1'b0;
      else if (cyc_start) zc_seen_q <= 1'b0;
      else if (zc_evt)    zc_seen_q <= 1'b1;
   end

   lla_run_counter #(.LIMIT(ENTRY_CNT)) i_entry (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mode_q || !allowed),
      .step  (cyc_start),
      .hit   (zc_seen_q || zc_evt),
      .done  (entry_done)
   );

   lla_run_counter #(.LIMIT(EXIT_CNT)) i_exit (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!mode_q),
      .step  (zc_in_low),
      .hit   (vs_below_ref),
      .done  (exit_done)
   );

   assign leave = mode_q && (!allowed || vs_below_95 || exit_done);
   assign run   = mode_q && !leave;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mode_q <= 1'b0;
      else if (leave)                     mode_q <= 1'b0;
      else if (!mode_q && entry_done)     mode_q <= 1'b1;
   end

   lla_pulse_seq #(.TON_CYC(TON_CYC)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .fire_req  (vs_below_ref),
      .i_pos     (i_pos),
      .zc_evt    (zc_evt),
      .state     (state),
      .zc_in_low (zc_in_low)
   );

   lla_drive_mux i_mux (
      .ll_mode (mode_q),
      .state   (state),
      .pwm_hs  (pwm_hs),
      .pwm_ls  (pwm_ls),
      .hs_on   (hs_on),
      .ls_on   (ls_on)
   );

   assign ll_mode = mode_q;
endmodule

// File: rtl/lla_mode_ctrl_chk.sv
module lla_mode_ctrl_chk #(
   parameter int TON_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic ll_enable,
   input logic track_mode,
   input logic ref_settled,
   input logic cyc_start,
   input logic i_pos,
   input logic vs_below_95,
   input logic ll_mode,
   input logic hs_on,
   input logic ls_on
);
   localparam int RW = $clog2(TON_CYC + 2);
   logic [RW-1:0] hs_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             hs_run_q <= '0;
      else if (ll_mode && hs_on && hs_run_q != '1) hs_run_q <= hs_run_q + 1'b1;
      else if (!(ll_mode && hs_on))           hs_run_q <= '0;
   end

   AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ll_mode) |-> $past(cyc_start)) else $error("entry off boundary"); // R1
   AST_PULSE_WIDTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_mode && hs_on) |-> (hs_run_q < RW'(TON_CYC))) else $error("pulse too long"); // R2
   AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      ll_mode |-> !(hs_on && ls_on)) else $error("both switches on"); // R3
   AST_HOLD_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_mode && !hs_on && !ls_on && i_pos) |=> (!ll_mode || !hs_on)) else $error("pulse not held"); // R5
   AST_DROOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_mode && vs_below_95) |=> !ll_mode) else $error("no droop exit"); // R6
   AST_TRACK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      track_mode |=> !ll_mode) else $error("tracking lockout"); // R8
   AST_SETTLE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_settled |=> !ll_mode) else $error("settle lockout"); // R9
   AST_ENABLE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !ll_enable |=> !ll_mode) else $error("enable lockout"); // R10
endmodule

bind lla_mode_ctrl lla_mode_ctrl_chk #(.TON_CYC(TON_CYC)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ll_enable   (ll_enable),
   .track_mode  (track_mode),
   .ref_settled (ref_settled),
   .cyc_start   (cyc_start),
   .i_pos       (i_pos),
   .vs_below_95 (vs_below_95),
   .ll_mode     (ll_mode),
   .hs_on       (hs_on),
   .ls_on       (ls_on)
);

// File: tb/test_lla_mode_ctrl.sv
module test_lla_mode_ctrl;
   localparam int ENTRY = 8;
   localparam int TON   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ll_enable = 1'b1, track_mode = 1'b0, ref_settled = 1'b1;
   logic cyc_start = 1'b0, zc_evt = 1'b0, i_pos = 1'b0;
   logic vs_below_ref = 1'b0, vs_below_95 = 1'b0;
   logic pwm_hs = 1'b1, pwm_ls = 1'b0;
   logic ll_mode, hs_on, ls_on;

   int n_chk = 0;
   int n_err = 0;
   bit done_flag = 0;

   always #2.5 clk = ~clk;

   lla_mode_ctrl i_lla_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .ll_enable(ll_enable), .track_mode(track_mode),
      .ref_settled(ref_settled), .cyc_start(cyc_start), .zc_evt(zc_evt), .i_pos(i_pos),
      .vs_below_ref(vs_below_ref), .vs_below_95(vs_below_95), .pwm_hs(pwm_hs),
      .pwm_ls(pwm_ls), .ll_mode(ll_mode), .hs_on(hs_on), .ls_on(ls_on)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ll_enable = 1'b1; track_mode = 1'b0; ref_settled = 1'b1;
      cyc_start = 1'b0; zc_evt = 1'b0; i_pos = 1'b0; vs_below_ref = 1'b0;
      vs_below_95 = 1'b0; pwm_hs = 1'b1; pwm_ls = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   // one PWM switching cycle, optionally with a zero crossing inside it
   task automatic pwm_cyc(input bit zc);
      zc_evt = zc; tick(); zc_evt = 1'b0;
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
   endtask

   task automatic enter_ll();
      for (int i = 0; i < ENTRY; i++) pwm_cyc(1'b1);
   endtask

   // one light-load pulse, ending with a zero crossing at the given comparator level
   task automatic ll_pulse(input bit below);
      vs_below_ref = 1'b1; i_pos = 1'b0; tick(); vs_below_ref = 1'b0;
      repeat (TON) tick();
      vs_below_ref = below; zc_evt = 1'b1; tick();
      zc_evt = 1'b0; vs_below_ref = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int run, w;
      bit pat [6];
      // R12 reset state and pass-through
      do_reset();
      chk("R12 reset mode", ll_mode, 0);
      chk("R12 pass hs", hs_on, 1);
      pwm_hs = 1'b0; pwm_ls = 1'b1; tick();
      chk("R12 pass ls", ls_on, 1);
      pwm_hs = 1'b1; pwm_ls = 1'b0;

      // R1 / R11: break position sweep
      for (int brk = 0; brk < ENTRY; brk++) begin
         do_reset();
         for (int i = 0; i < brk; i++) begin
            pwm_cyc(1'b1);
            chk("R1 pre-run", ll_mode, 0);
         end
         pwm_cyc(1'b0);
         chk("R11 broken cycle", ll_mode, 0);
         run = 0;
         for (int i = 0; i < ENTRY; i++) begin
            pwm_cyc(1'b1);
            run++;
            chk("R1 run entry", ll_mode, (run == ENTRY) ? 1 : 0);
         end
      end

      // R1: crossing coincident with cyc_start counts
      do_reset();
      for (int i = 0; i < ENTRY; i++) begin
         zc_evt = 1'b1; cyc_start = 1'b1; tick(); zc_evt = 1'b0; cyc_start = 1'b0;
      end
      chk("R1 coincident crossing", ll_mode, 1);

      // R8 R9 R10: lockouts block entry
      for (int lk = 0; lk < 3; lk++) begin
         do_reset();
         track_mode  = (lk == 0);
         ref_settled = (lk != 1);
         ll_enable   = (lk != 2);
         for (int i = 0; i < ENTRY + 2; i++) pwm_cyc(1'b1);
         if (lk == 0)      chk("R8 track blocks entry", ll_mode, 0);
         else if (lk == 1) chk("R9 unsettled blocks entry", ll_mode, 0);
         else              chk("R10 disabled blocks entry", ll_mode, 0);
      end

      // R10: enable drop clears the run
      do_reset();
      for (int i = 0; i < 5; i++) pwm_cyc(1'b1);
      ll_enable = 1'b0; tick(); ll_enable = 1'b1;
      for (int i = 0; i < ENTRY; i++) begin
         pwm_cyc(1'b1);
         chk("R10 run restarted", ll_mode, (i == ENTRY - 1) ? 1 : 0);
      end

      // R2 R3 R4 R5: light-load pulse sequence
      do_reset();
      enter_ll();
      chk("R4 idle hs", hs_on, 0);
      chk("R4 idle ls", ls_on, 0);
      vs_below_ref = 1'b1; i_pos = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R5 held back", hs_on, 0);
      end
      i_pos = 1'b0; tick();
      chk("R4 pulse fired", hs_on, 1);
      vs_below_ref = 1'b0;
      w = 1;
      for (int i = 0; i < 20; i++) begin
         tick();
         if (hs_on) w++;
         else break;
      end
      chk("R2 pulse width", w, TON);
      chk("R3 low side after pulse", ls_on, 1);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R3 low side held", ls_on, 1);
         chk("R3 high side off", hs_on, 0);
      end
      zc_evt = 1'b1; tick(); zc_evt = 1'b0;
      chk("R3 off after zero hs", hs_on, 0);
      chk("R3 off after zero ls", ls_on, 0);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R4 waits for reference", hs_on, 0);
      end
      chk("R4 still light", ll_mode, 1);

      // R7: exit run with one interruption
      pat = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
      run = 0;
      for (int i = 0; i < 6; i++) begin
         ll_pulse(pat[i]);
         run = pat[i] ? run + 1 : 0;
         chk("R7 exit count", ll_mode, (run >= 3) ? 0 : 1);
      end
      chk("R12 after exit hs", hs_on, 1);

      // R6: droop exit mid-pulse
      do_reset();
      enter_ll();
      pwm_hs = 1'b0; pwm_ls = 1'b1;
      vs_below_ref = 1'b1; tick(); vs_below_ref = 1'b0;
      chk("R6 pulse on", hs_on, 1);
      vs_below_95 = 1'b1; tick(); vs_below_95 = 1'b0;
      chk("R6 droop exit", ll_mode, 0);
      chk("R6 pwm hs", hs_on, 0);
      chk("R6 pwm ls", ls_on, 1);

      // R8: tracking forces exit
      do_reset();
      enter_ll();
      track_mode = 1'b1; tick(); track_mode = 1'b0;
      chk("R8 track exit", ll_mode, 0);

      // R9: reference change forces exit and a full new run
      do_reset();
      enter_ll();
      ref_settled = 1'b0; tick();
      chk("R9 settle exit", ll_mode, 0);
      pwm_cyc(1'b1);
      ref_settled = 1'b1;
      for (int i = 0; i < ENTRY; i++) begin
         pwm_cyc(1'b1);
         chk("R9 re-entry run", ll_mode, (i == ENTRY - 1) ? 1 : 0);
      end

      finish_run();
   end
endmodule